// File: doc/BRIEF.md
# One-of-N Scan Segment Selector

This block is a reconfigurable element of a test-data-register scan path. It steers the active shift path from TDI through exactly one of N attached register segments, or through a one-bit default bypass cell, and then on to TDO. A multi-bit selection field sits ahead of the segments in the chain and is never part of any segment it chooses. The field has a shift stage and an update stage. Only the update stage steers the path, so shifting a new code leaves the current routing in place until an update-DR event.

The TAP controller supplies the capture, shift and update strobes, a block select and an asynchronous test reset. The block gives every segment the scan-in bit from the end of the selection field. It also gives each segment its own gated shift, capture and update enables, so a segment that is not selected keeps its contents. An output multiplexer after the segment list picks the selected segment's scan-out or the bypass cell.

Top module: `scan_sel_router`

## Requirements
- R1: With an update-stage code k in 1..NUM_SEG, segment k-1 sits between the selection field and TDO: tdo equals segScanOut[k-1], and that segment shifts by one bit per shift cycle.
- R2: Code 0 or any code above NUM_SEG selects a one-bit bypass cell, so the path from TDI to TDO is SEL_W+1 bits long.
- R3: While testRst is high, the selection shift and update stages and the bypass cell are cleared to 0, which selects the bypass path, and no segment enable is asserted.
- R4: A code shifted into the selection field does not change the routing until it is transferred by an update cycle.
- R5: Capture and shift act on the rising edge of tck. The update stage loads on the falling edge of tck in a cycle with selectIn and updateDr high, so tdo follows the old path before that edge and the new path after it.
- R6: segShiftEn has at most one bit set: the bit of the selected segment, and only while selectIn and shiftDr are high. A segment not selected holds its contents.
- R7: On a capture cycle the selection shift stage loads the update-stage code (readback) and the bypass cell loads 0. segCaptureEn and segUpdateEn are set only for the selected segment.
- R8: The chain order is tdi, then the SEL_W-bit selection field, then the selected path. Codes are shifted least significant bit first, and every segScanIn bit carries the field's last bit.
- R9: While selectIn is low, capture, shift and update strobes have no effect, and all segment enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| testRst | input | 1 | Asynchronous test reset, active high |
| selectIn | input | 1 | This register is the one addressed by the current instruction |
| captureDr | input | 1 | Capture-DR state strobe |
| shiftDr | input | 1 | Shift-DR state strobe |
| updateDr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out from the selected path |
| segScanIn | output | NUM_SEG | Scan-in to each segment |
| segScanOut | input | NUM_SEG | Scan-out from each segment |
| segShiftEn | output | NUM_SEG | Per-segment shift enable |
| segCaptureEn | output | NUM_SEG | Per-segment capture enable |
| segUpdateEn | output | NUM_SEG | Per-segment update enable |

## Verification
The bench attaches segments of lengths 2 to 5 and never lets them capture. Data left in a segment therefore comes back out on a later scan: a design that shifted unselected segments, or let two shift together, returns a corrupted bit stream. Unused codes (0, and 5 to 7 with four segments) are loaded on purpose. A decoder that wrapped them onto a segment would show a path length other than SEL_W+1. Scans that end without an update, and strobes sent while the block is deselected, must leave the routing alone. tdo is sampled on both sides of the falling edge in an update cycle, which catches an update stage clocked on the wrong edge or driven from the shift stage.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic fieldCap;    // selection shift stage loads readback
    logic fieldShift;  // selection shift stage shifts
    logic fieldUpd;    // selection update stage loads (falling edge)
    logic bypCap;      // bypass cell clears
    logic bypShift;    // bypass cell shifts
  } selStrobe_t;

endpackage

// File: rtl/scan_sel_ctrl.sv
module scan_sel_ctrl
  import scan_sel_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = 3
) (
  input  logic               tck,
  input  logic               testRst,
  input  logic               selectIn,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic [SEL_W-1:0]   selUpd,
  output selStrobe_t         strobe,
  output logic [NUM_SEG-1:0] segHit,
  output logic               bypHit,
  output logic [NUM_SEG-1:0] segShiftEn,
  output logic [NUM_SEG-1:0] segCaptureEn,
  output logic [NUM_SEG-1:0] segUpdateEn
);

  logic capSel;
  logic shSel;
  logic updSel;

  assign capSel = selectIn & captureDr;
  assign shSel  = selectIn & shiftDr;
  assign updSel = selectIn & updateDr;

  // code i+1 selects segment i; everything else falls to the bypass cell
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_dec
    assign segHit[i]       = (selUpd == SEL_W'(i + 1));
    assign segShiftEn[i]   = segHit[i] & shSel;
    assign segCaptureEn[i] = segHit[i] & capSel;
    assign segUpdateEn[i]  = segHit[i] & updSel;
  end

  assign bypHit = ~|segHit;

  always_comb begin
    strobe            = '0;
    strobe.fieldCap   = capSel;
    strobe.fieldShift = shSel;
    strobe.fieldUpd   = updSel;
    strobe.bypCap     = capSel & bypHit;
    strobe.bypShift   = shSel & bypHit;
  end

  // R6
  one_shift_chk: assert property (@(posedge tck) disable iff (testRst)
    $onehot0(segShiftEn));

  // R6
  shift_gate_chk: assert property (@(posedge tck) disable iff (testRst)
    (segShiftEn != '0) |-> (shiftDr && selectIn && !bypHit));

  // R9
  desel_quiet_chk: assert property (@(posedge tck) disable iff (testRst)
    !selectIn |-> (segShiftEn == '0 && segCaptureEn == '0 && segUpdateEn == '0));

  // R2
  byp_excl_chk: assert property (@(posedge tck) disable iff (testRst)
    (selUpd == '0 || selUpd > SEL_W'(NUM_SEG)) |-> (segShiftEn == '0 && segCaptureEn == '0));

endmodule

// File: rtl/scan_sel_dp.sv
module scan_sel_dp
  import scan_sel_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = 3
) (
  input  logic               tck,
  input  logic               testRst,
  input  logic               tdi,
  input  selStrobe_t         strobe,
  input  logic [NUM_SEG-1:0] segHit,
  input  logic [NUM_SEG-1:0] segScanOut,
  output logic [SEL_W-1:0]   selUpd,
  output logic [NUM_SEG-1:0] segScanIn,
  output logic               tdo
);

  logic [SEL_W-1:0] selShift;
  logic             bypBit;
  logic             fieldOut;

  assign fieldOut = selShift[0];

  // selection shift stage: tdi enters at the top, bit 0 feeds the segments
  always_ff @(posedge tck or posedge testRst) begin
    if (testRst) begin
      selShift <= '0;
    end else if (strobe.fieldCap) begin
      selShift <= selUpd;
    end else if (strobe.fieldShift) begin
      selShift <= {tdi, selShift[SEL_W-1:1]};
    end
  end

  // selection update stage on the falling edge
  always_ff @(negedge tck or posedge testRst) begin
    if (testRst) begin
      selUpd <= '0;
    end else if (strobe.fieldUpd) begin
      selUpd <= selShift;
    end
  end

  // default one-bit path
  always_ff @(posedge tck or posedge testRst) begin
    if (testRst) begin
      bypBit <= 1'b0;
    end else if (strobe.bypCap) begin
      bypBit <= 1'b0;
    end else if (strobe.bypShift) begin
      bypBit <= fieldOut;
    end
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_si
    assign segScanIn[i] = fieldOut;
  end

  // output multiplexer after the segment list
  always_comb begin
    tdo = bypBit;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (segHit[i]) tdo = segScanOut[i];
    end
  end

  // R4
  upd_hold_chk: assert property (@(posedge tck) disable iff (testRst)
    !strobe.fieldUpd |-> $stable(selUpd));

  // R7
  readback_chk: assert property (@(posedge tck) disable iff (testRst)
    strobe.fieldCap |=> (selShift == $past(selUpd)));

  // R7
  byp_clear_chk: assert property (@(posedge tck) disable iff (testRst)
    strobe.bypCap |=> !bypBit);

  // R8
  field_shift_chk: assert property (@(posedge tck) disable iff (testRst)
    (strobe.fieldShift && !strobe.fieldCap) |=> (selShift[SEL_W-1] == $past(tdi)));

endmodule

// File: rtl/scan_sel_router.sv
module scan_sel_router
  import scan_sel_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = 3
) (
  input  logic               tck,
  input  logic               testRst,
  input  logic               selectIn,
  input  logic               captureDr,
  input  logic               shiftDr,
  input  logic               updateDr,
  input  logic               tdi,
  output logic               tdo,
  output logic [NUM_SEG-1:0] segScanIn,
  input  logic [NUM_SEG-1:0] segScanOut,
  output logic [NUM_SEG-1:0] segShiftEn,
  output logic [NUM_SEG-1:0] segCaptureEn,
  output logic [NUM_SEG-1:0] segUpdateEn
);

  localparam int CODE_SPAN = 1 << SEL_W;

  initial begin
    if (CODE_SPAN <= NUM_SEG) $error("SEL_W too narrow for NUM_SEG codes plus bypass");
  end

  selStrobe_t         strobe;
  logic [SEL_W-1:0]   selUpd;
  logic [NUM_SEG-1:0] segHit;
  logic               bypHit;

  scan_sel_ctrl #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_ctrl (
    .tck          (tck),
    .testRst      (testRst),
    .selectIn     (selectIn),
    .captureDr    (captureDr),
    .shiftDr      (shiftDr),
    .updateDr     (updateDr),
    .selUpd       (selUpd),
    .strobe       (strobe),
    .segHit       (segHit),
    .bypHit       (bypHit),
    .segShiftEn   (segShiftEn),
    .segCaptureEn (segCaptureEn),
    .segUpdateEn  (segUpdateEn)
  );

  scan_sel_dp #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_dp (
    .tck        (tck),
    .testRst    (testRst),
    .tdi        (tdi),
    .strobe     (strobe),
    .segHit     (segHit),
    .segScanOut (segScanOut),
    .selUpd     (selUpd),
    .segScanIn  (segScanIn),
    .tdo        (tdo)
  );

endmodule

// File: tb/scan_sel_router_bench.sv
module scan_sel_router_bench;

  localparam int NUM_SEG = 4;
  localparam int SEL_W   = 3;

  logic tck = 1'b0;
  logic testRst = 1'b1;
  logic selectIn = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NUM_SEG-1:0] segScanIn, segScanOut, segShiftEn, segCaptureEn, segUpdateEn;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 tck = ~tck;

  scan_sel_router #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_scan_sel_router (
    .tck(tck), .testRst(testRst), .selectIn(selectIn), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .segScanIn(segScanIn), .segScanOut(segScanOut), .segShiftEn(segShiftEn),
    .segCaptureEn(segCaptureEn), .segUpdateEn(segUpdateEn)
  );

  function automatic int segLen(int i);
    return i + 2;
  endfunction

  function automatic logic [7:0] segSeed(int i);
    return (8'h5A ^ 8'(i * 37)) & ((8'd1 << segLen(i)) - 8'd1);
  endfunction

  // behavioural segments attached to the block (shift only, no capture)
  logic [7:0] segReg [NUM_SEG];
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    always @(posedge tck or posedge testRst) begin
      if (testRst) segReg[g] <= segSeed(g);
      else if (segShiftEn[g])
        segReg[g] <= (segReg[g] >> 1) | (8'(segScanIn[g]) << (segLen(g) - 1));
    end
    assign segScanOut[g] = segReg[g][0];
  end

  // bench reference model of the chain
  logic [SEL_W-1:0] mField, mUpd;
  logic             mByp;
  logic [7:0]       mSeg [NUM_SEG];

  function automatic int activeSeg(logic [SEL_W-1:0] code);
    if (code >= 1 && code <= NUM_SEG) return int'(code) - 1;
    return -1;
  endfunction

  function automatic logic expTdo();
    int a = activeSeg(mUpd);
    return (a < 0) ? mByp : mSeg[a][0];
  endfunction

  function automatic logic [NUM_SEG-1:0] expEn(logic on);
    int a = activeSeg(mUpd);
    if (!on || a < 0) return '0;
    return NUM_SEG'(1) << a;
  endfunction

  task automatic modelReset();
    mField = '0; mUpd = '0; mByp = 1'b0;
    for (int i = 0; i < NUM_SEG; i++) mSeg[i] = segSeed(i);
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic checkN(string req, string what, logic [NUM_SEG-1:0] act, logic [NUM_SEG-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // one tck cycle: drive after the rising edge, check on both sides of the falling edge
  task automatic step(logic sel, logic cap, logic sh, logic upd, logic din);
    string pathReq;
    int a;
    @(posedge tck);
    #1;
    selectIn = sel; captureDr = cap; shiftDr = sh; updateDr = upd; tdi = din;
    #2;
    pathReq = (activeSeg(mUpd) < 0) ? "R2" : "R1";
    check1((sel && upd) ? "R5" : pathReq, "tdo before falling edge", tdo, expTdo());
    #4;
    if (sel && upd) mUpd = mField;
    pathReq = (activeSeg(mUpd) < 0) ? "R2" : "R1";
    check1((sel && upd) ? "R5" : pathReq, "tdo after falling edge", tdo, expTdo());
    checkN(sel ? "R6" : "R9", "segShiftEn", segShiftEn, expEn(sel && sh));
    if (cap || upd) begin
      checkN(sel ? "R7" : "R9", "segCaptureEn", segCaptureEn, expEn(sel && cap));
      checkN(sel ? "R7" : "R9", "segUpdateEn", segUpdateEn, expEn(sel && upd));
    end
    // model the coming rising edge
    if (sel && cap) begin
      mField = mUpd;
      if (activeSeg(mUpd) < 0) mByp = 1'b0;
    end else if (sel && sh) begin
      a = activeSeg(mUpd);
      if (a < 0) mByp = mField[0];
      else mSeg[a] = (mSeg[a] >> 1) | (8'(mField[0]) << (segLen(a) - 1));
      mField = {din, mField[SEL_W-1:1]};
    end
  endtask

  // capture, shift 'pre' filler bits then the code LSB first (R8), optional update
  task automatic scan(logic [SEL_W-1:0] code, int pre, logic doUpd);
    step(1, 1, 0, 0, 0);
    for (int k = 0; k < pre; k++) step(1, 0, 1, 0, 1'($urandom));
    for (int k = 0; k < SEL_W; k++) step(1, 0, 1, 0, code[k]);
    step(1, 0, 0, doUpd, 0);
    step(0, 0, 0, 0, 0);
  endtask

  task automatic applyReset();
    @(posedge tck);
    #1;
    testRst = 1'b1;
    selectIn = 0; captureDr = 0; shiftDr = 0; updateDr = 0;
    modelReset();
    #3;
    // R3: bypass selected and all enables low while in reset
    check1("R3", "tdo in reset", tdo, 1'b0);
    checkN("R3", "segShiftEn in reset", segShiftEn, '0);
    @(posedge tck);
    #1;
    testRst = 1'b0;
  endtask

  always @(posedge tck) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    modelReset();
    applyReset();

    // R3 / R2: after reset the readback is code 0 through the bypass cell
    scan(3'd0, 0, 1);
    // R1: each segment in turn, R8 code order, with varied fill
    scan(3'd1, 2, 1);
    scan(3'd2, 1, 1);
    scan(3'd3, 4, 1);
    scan(3'd4, 3, 1);
    // R6: segment 1 held its data while others shifted; reselect it
    scan(3'd2, 5, 1);
    // R4: shift a new code without update, routing must stay on segment 1
    scan(3'd4, 2, 0);
    scan(3'd3, 0, 0);
    // R2: unused codes and the top code
    scan(3'd5, 1, 1);
    scan(3'd7, 2, 1);
    scan(3'd6, 0, 1);
    scan(3'd1, 3, 1);
    // R9: strobes while deselected do nothing
    step(0, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 1'b1);
    step(0, 0, 0, 1, 0);
    scan(3'd3, 1, 1);
    // R3: reset in mid-run returns to the bypass path
    applyReset();
    scan(3'd0, 1, 1);

    // constrained random scans
    for (int n = 0; n < 40; n++) begin
      logic [SEL_W-1:0] c = SEL_W'($urandom);
      scan(c, int'($urandom % 7), ($urandom % 4) != 0);
      if (($urandom % 5) == 0) begin
        step(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule